// File: doc/BRIEF.md
# Configuration Frame Scrubber

This block repairs single-event upsets in a device's configuration memory by comparing it with a trusted image. It visits the frames one at a time. For each frame it first fetches the whole golden copy from an external non-volatile flash into a local frame buffer. It then reads the live frame back word by word through the configuration read port. While the readback streams in, each live word is XORed with the buffered golden word and the result is folded into a sticky mismatch flag.

After the readback ends, a frame with even one differing bit is written back in full from the buffer. A frame that matches is never written. Each rewrite increments a saturating upset counter. It also produces a one-cycle strobe and records the index of the repaired frame, so that upset rates can be logged while the device is running.

Scrubbing starts at frame 0 on a `start` pulse. The frame index wraps from the last frame back to 0 for as long as scrubbing stays enabled. A `stop` pulse lets the frame in progress finish, including its rewrite, before the block returns to idle. Every external port uses a valid/ready handshake and may be stalled for any number of cycles.

Top module: `frame_scrubber`

## Requirements
- R1: While reset is held and after it is released, `busy`, `fix_pulse`, `upset_cnt`, `last_fix_frame`, `fl_valid`, `cr_valid` and `cw_valid` are all 0.
- R2: For each frame, all FRAME_WORDS golden words are fetched from flash before the first live word of that frame is read. The flash word address is frame*FRAME_WORDS + word.
- R3: A frame whose readback differs from the golden copy in at least one bit is rewritten completely. After the rewrite every word of that frame equals the golden copy.
- R4: A frame whose readback equals the golden copy produces no write request at all.
- R5: `upset_cnt` increases by exactly one for each rewritten frame, no matter how many bits or words of that frame were wrong.
- R6: `upset_cnt` saturates at 2^CNT_W-1 and does not wrap.
- R7: Each rewrite produces a `fix_pulse` that is exactly one cycle wide, with `last_fix_frame` holding the index of the rewritten frame.
- R8: While scrubbing is enabled, the frame after frame FRAME_COUNT-1 is frame 0.
- R9: After `stop`, the frame in progress, including a rewrite already begun or still due, is completed. The block then returns to idle (`busy`=0) without fetching any further frame.
- R10: A `start` pulse in idle makes the first flash request address word 0 of frame 0.
- R11: A request that is valid but not accepted stays valid, and its address and data stay unchanged, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin scrubbing from frame 0 (taken only when idle) |
| stop | input | 1 | Finish the current frame, then go idle |
| fl_valid | output | 1 | Flash word read request |
| fl_addr | output | FL_W | Flash word address |
| fl_ready | input | 1 | Flash accepts the request; fl_data valid this cycle |
| fl_data | input | WORD_W | Golden word |
| cr_valid | output | 1 | Configuration readback request |
| cr_frame | output | FA_W | Frame index for readback |
| cr_word | output | WI_W | Word index for readback |
| cr_ready | input | 1 | Readback accepted; cr_data valid this cycle |
| cr_data | input | WORD_W | Live configuration word |
| cw_valid | output | 1 | Configuration write request |
| cw_frame | output | FA_W | Frame index for write |
| cw_word | output | WI_W | Word index for write |
| cw_data | output | WORD_W | Golden word to write |
| cw_ready | input | 1 | Write accepted |
| busy | output | 1 | Scrubbing in progress |
| fix_pulse | output | 1 | One-cycle strobe per repaired frame |
| last_fix_frame | output | FA_W | Index of the most recently repaired frame |
| upset_cnt | output | CNT_W | Saturating count of repaired frames |

## Verification
A read word is taken on the very edge where valid and ready meet, so the bench decides ready, supplies the data and records writes at the falling edge before that rising edge. `fix_pulse`, `last_fix_frame` and `upset_cnt` change on the edge that accepts the last write word of a frame, which makes them visible one cycle later. The bench samples them at the next falling edge, and it compares the counter and the configuration image only after `busy` has fallen at the end of a pass. Live-read ordering, stall holding and strobe width are checked continuously on every falling edge rather than at fixed offsets, because the bench's ready patterns make every phase take a variable number of cycles.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_GOLD,
    S_LIVE,
    S_CMP,
    S_FIX,
    S_NEXT
  } scrub_state_t;
endpackage

// File: rtl/scrub_gold_buf.sv
module scrub_gold_buf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scrub_mismatch.sv
module scrub_mismatch #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [WORD_W-1:0] live_w,
  input  logic [WORD_W-1:0] gold_w,
  output logic              bad
);
  function automatic logic word_differs(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    return |(a ^ b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) bad <= 1'b0;
    else if (en)       bad <= bad | word_differs(live_w, gold_w);
  end

  // R3: once a difference has been seen the flag stays set until cleared
  assert_bad_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad && !clr |=> bad);
endmodule

// File: rtl/scrub_upset_ctr.sv
module scrub_upset_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= sat_inc(count);
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> (&count));

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/frame_scrubber.sv
module frame_scrubber
  import scrub_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 16,
  parameter int FRAME_COUNT = 64,
  parameter int CNT_W       = 16,
  localparam int WI_W = $clog2(FRAME_WORDS),
  localparam int FA_W = $clog2(FRAME_COUNT),
  localparam int FL_W = $clog2(FRAME_COUNT * FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  output logic              fl_valid,
  output logic [FL_W-1:0]   fl_addr,
  input  logic              fl_ready,
  input  logic [WORD_W-1:0] fl_data,
  output logic              cr_valid,
  output logic [FA_W-1:0]   cr_frame,
  output logic [WI_W-1:0]   cr_word,
  input  logic              cr_ready,
  input  logic [WORD_W-1:0] cr_data,
  output logic              cw_valid,
  output logic [FA_W-1:0]   cw_frame,
  output logic [WI_W-1:0]   cw_word,
  output logic [WORD_W-1:0] cw_data,
  input  logic              cw_ready,
  output logic              busy,
  output logic              fix_pulse,
  output logic [FA_W-1:0]   last_fix_frame,
  output logic [CNT_W-1:0]  upset_cnt
);
  function automatic logic [FA_W-1:0] next_frame(logic [FA_W-1:0] f);
    return (f == FA_W'(FRAME_COUNT - 1)) ? '0 : f + 1'b1;
  endfunction

  function automatic logic [FL_W-1:0] flash_addr(logic [FA_W-1:0] f, logic [WI_W-1:0] w);
    return FL_W'(f) * FL_W'(FRAME_WORDS) + FL_W'(w);
  endfunction

  function automatic logic [WI_W-1:0] next_word(logic [WI_W-1:0] w);
    return (w == WI_W'(FRAME_WORDS - 1)) ? '0 : w + 1'b1;
  endfunction

  scrub_state_t      st;
  logic [FA_W-1:0]   frame;
  logic [WI_W-1:0]   word;
  logic              stop_pend;
  logic [WORD_W-1:0] gold_rd;

  // named internal events
  logic last_word, gold_hs, live_hs, fix_hs, frame_fixed, frame_bad, stop_req, cmp_clr;
  assign last_word   = (word == WI_W'(FRAME_WORDS - 1));
  assign gold_hs     = (st == S_GOLD) && fl_ready;
  assign live_hs     = (st == S_LIVE) && cr_ready;
  assign fix_hs      = (st == S_FIX)  && cw_ready;
  assign frame_fixed = fix_hs && last_word;
  assign stop_req    = stop_pend || stop;
  assign cmp_clr     = (st == S_IDLE) || (st == S_NEXT);

  scrub_gold_buf #(.WORD_W(WORD_W), .DEPTH(FRAME_WORDS)) u_buf (
    .clk   (clk),
    .we    (gold_hs),
    .waddr (word),
    .wdata (fl_data),
    .raddr (word),
    .rdata (gold_rd)
  );

  scrub_mismatch #(.WORD_W(WORD_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cmp_clr),
    .en     (live_hs),
    .live_w (cr_data),
    .gold_w (gold_rd),
    .bad    (frame_bad)
  );

  scrub_upset_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_fixed),
    .count (upset_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      frame     <= '0;
      word      <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (st == S_IDLE)  stop_pend <= 1'b0;
      else if (stop)     stop_pend <= 1'b1;
      unique case (st)
        S_IDLE: if (start) begin
          st    <= S_GOLD;
          frame <= '0;
          word  <= '0;
        end
        S_GOLD: if (gold_hs) begin
          word <= next_word(word);
          if (last_word) st <= S_LIVE;
        end
        S_LIVE: if (live_hs) begin
          word <= next_word(word);
          if (last_word) st <= S_CMP;
        end
        S_CMP: st <= frame_bad ? S_FIX : S_NEXT;
        S_FIX: if (fix_hs) begin
          word <= next_word(word);
          if (last_word) st <= S_NEXT;
        end
        S_NEXT: begin
          frame <= next_frame(frame);
          st    <= stop_req ? S_IDLE : S_GOLD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_pulse      <= 1'b0;
      last_fix_frame <= '0;
    end else begin
      fix_pulse <= frame_fixed;
      if (frame_fixed) last_fix_frame <= frame;
    end
  end

  assign busy     = (st != S_IDLE);
  assign fl_valid = (st == S_GOLD);
  assign fl_addr  = flash_addr(frame, word);
  assign cr_valid = (st == S_LIVE);
  assign cr_frame = frame;
  assign cr_word  = word;
  assign cw_valid = (st == S_FIX);
  assign cw_frame = frame;
  assign cw_word  = word;
  assign cw_data  = gold_rd;

  assert_fl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_addr));

  assert_cw_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_data) && $stable(cw_word) && $stable(cw_frame));

  assert_live_after_gold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_valid) |-> $past(fl_valid));

  assert_write_only_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> frame_bad);

  assert_strobe_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_pulse |=> !fix_pulse);

  assert_idle_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st == S_NEXT));
endmodule

// File: tb/tb_frame_scrubber.sv
module tb_frame_scrubber;
  localparam int WW   = 32;
  localparam int FW   = 16;
  localparam int FC   = 64;
  localparam int CW   = 3;
  localparam int CMAX = 7;
  localparam int FLW  = $clog2(FC * FW);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, stop;
  logic fl_valid, fl_ready, cr_valid, cr_ready, cw_valid, cw_ready;
  logic [FLW-1:0] fl_addr;
  logic [WW-1:0] fl_data, cr_data, cw_data;
  logic [5:0] cr_frame, cw_frame, last_fix_frame;
  logic [3:0] cr_word, cw_word;
  logic busy, fix_pulse;
  logic [CW-1:0] upset_cnt;

  frame_scrubber #(.WORD_W(WW), .FRAME_WORDS(FW), .FRAME_COUNT(FC), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_ready(fl_ready), .fl_data(fl_data),
    .cr_valid(cr_valid), .cr_frame(cr_frame), .cr_word(cr_word), .cr_ready(cr_ready), .cr_data(cr_data),
    .cw_valid(cw_valid), .cw_frame(cw_frame), .cw_word(cw_word), .cw_data(cw_data), .cw_ready(cw_ready),
    .busy(busy), .fix_pulse(fix_pulse), .last_fix_frame(last_fix_frame), .upset_cnt(upset_cnt));

  function automatic logic [WW-1:0] gold(int f, int w);
    return 32'h5A3C96E1 ^ (32'(f * FW + w) * 32'h9E3779B1);
  endfunction

  logic [WW-1:0] live [FC][FW];
  int errors = 0, checks = 0, cyc = 0;
  int writes, pulses, pulse_run, pulse_wide, frames_read, last_rd_frame, prev_frame;
  int order_err, hold_err, first_addr;
  bit wrap_seen, first_pending, gold_done, fl_stalled, done;
  logic [FLW-1:0] stalled_addr;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // environment: ready patterns, data, monitors (all at the falling edge)
  always @(negedge clk) begin
    int fr, wd;
    bit flr, crr, cwr;
    cyc++;
    flr = (cyc % 3) != 0;
    crr = (cyc % 4) != 1;
    cwr = (cyc % 5) != 2;
    if (fl_stalled && !(fl_valid && fl_addr == stalled_addr)) hold_err++;
    fl_stalled = fl_valid && !flr;
    stalled_addr = fl_addr;
    fl_ready = flr;
    cr_ready = crr;
    cw_ready = cwr;
    if (fl_valid && flr) begin
      fr = int'(fl_addr) / FW;
      wd = int'(fl_addr) % FW;
      fl_data = gold(fr, wd);
      if (wd == 0) begin
        if (first_pending) begin first_addr = int'(fl_addr); first_pending = 0; end
        if (prev_frame == FC - 1 && fr == 0) wrap_seen = 1;
        prev_frame = fr;
        last_rd_frame = fr;
        gold_done = 0;
      end
      if (wd == FW - 1) begin gold_done = 1; frames_read++; end
    end
    if (cr_valid && crr) begin
      if (!gold_done) order_err++;
      cr_data = live[cr_frame][cr_word];
    end
    if (cw_valid && cwr) begin
      live[cw_frame][cw_word] = cw_data;
      writes++;
    end
    if (rst_n && fix_pulse) begin
      pulses++;
      pulse_run++;
      if (pulse_run > 1) pulse_wide++;
    end else pulse_run = 0;
    if (cyc > 180000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 180000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic clear_mon();
    writes = 0; pulses = 0; pulse_wide = 0; frames_read = 0;
    wrap_seen = 0; first_pending = 1; order_err = 0; hold_err = 0;
    prev_frame = -1; last_rd_frame = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop_wait_idle();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pass(int nframes);
    clear_mon();
    pulse_start();
    while (frames_read < nframes) @(negedge clk);
    pulse_stop_wait_idle();
  endtask

  function automatic bit frame_ok(int f);
    for (int w = 0; w < FW; w++) if (live[f][w] !== gold(f, w)) return 0;
    return 1;
  endfunction

  typedef struct packed {
    logic [7:0]  f;
    logic [7:0]  w;
    logic [31:0] m;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'd0,  8'd0,  32'h0000_0001, 8'd1},
    '{8'd63, 8'd15, 32'h8000_0000, 8'd2},
    '{8'd5,  8'd7,  32'h0000_F00F, 8'd3},
    '{8'd0,  8'd0,  32'h0000_0000, 8'd3},
    '{8'd32, 8'd3,  32'h0000_0100, 8'd4}
  };

  initial begin
    for (int f = 0; f < FC; f++)
      for (int w = 0; w < FW; w++) live[f][w] = gold(f, w);
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    fl_ready = 0; cr_ready = 0; cw_ready = 0; fl_data = '0; cr_data = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    check(!busy && !fix_pulse && upset_cnt == 0, "R1", "state in reset", {busy, fix_pulse, upset_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fl_valid && !cr_valid && !cw_valid && !busy && last_fix_frame == 0,
          "R1", "idle after reset", {fl_valid, cr_valid, cw_valid, busy}, 0);

    for (int i = 0; i < 5; i++) begin
      int f, w;
      f = int'(VEC[i].f);
      w = int'(VEC[i].w);
      if (VEC[i].m != 0) live[f][w] ^= VEC[i].m;
      run_pass(FC + 1);
      check(upset_cnt == CW'(VEC[i].exp), "R5", "count after pass", upset_cnt, VEC[i].exp);
      check(live[f][w] === gold(f, w), "R3", "word restored", live[f][w], gold(f, w));
      if (VEC[i].m != 0) begin
        check(writes == FW, "R3", "whole frame written", writes, FW);
        check(pulses == 1, "R7", "one strobe", pulses, 1);
        check(last_fix_frame == 6'(f), "R7", "repaired frame index", last_fix_frame, f);
      end else begin
        check(writes == 0, "R4", "clean pass writes", writes, 0);
        check(pulses == 0, "R4", "clean pass strobes", pulses, 0);
      end
      check(wrap_seen, "R8", "frame 0 follows last frame", wrap_seen, 1);
      check(first_addr == 0, "R10", "first flash address", first_addr, 0);
      check(order_err == 0, "R2", "live read before golden done", order_err, 0);
      check(hold_err == 0, "R11", "stalled request held", hold_err, 0);
      check(pulse_wide == 0, "R7", "strobe width", pulse_wide, 0);
    end

    // two frames faulty in one pass, several words in one of them
    live[1][2] ^= 32'h10; live[1][9] ^= 32'h4; live[2][14] ^= 32'h2000_0000;
    run_pass(FC + 1);
    check(upset_cnt == 6, "R5", "one count per frame", upset_cnt, 6);
    check(writes == 2 * FW, "R3", "two frames rewritten", writes, 2 * FW);
    check(frame_ok(1) && frame_ok(2), "R3", "frames 1 and 2 restored", 0, 1);
    check(last_fix_frame == 6'd2, "R7", "last repaired frame", last_fix_frame, 2);

    // saturation: three more faults on a counter already at 6
    live[10][0] ^= 32'h1; live[20][5] ^= 32'h80; live[30][11] ^= 32'h400;
    run_pass(FC + 1);
    check(upset_cnt == CMAX, "R6", "counter saturated", upset_cnt, CMAX);
    check(pulses == 3, "R7", "strobes while saturating", pulses, 3);
    check(frame_ok(10) && frame_ok(20) && frame_ok(30), "R3", "all restored", 0, 1);

    // stop during a rewrite: frame completes, nothing further fetched
    live[10][9] ^= 32'h0F00_0000;
    clear_mon();
    pulse_start();
    while (!cw_valid) @(negedge clk);
    pulse_stop_wait_idle();
    check(!busy, "R9", "idle after stop", busy, 0);
    check(frame_ok(10), "R9", "interrupted frame complete", live[10][9], gold(10, 9));
    check(writes == FW, "R9", "full frame writes", writes, FW);
    check(last_rd_frame == 10, "R9", "no frame fetched after stop", last_rd_frame, 10);
    check(upset_cnt == CMAX, "R6", "still saturated", upset_cnt, CMAX);

    // stop during the golden read of frame 0 on a clean image
    clear_mon();
    pulse_start();
    pulse_stop_wait_idle();
    check(last_rd_frame == 0 && frames_read == 1, "R9", "stops after frame 0", last_rd_frame, 0);
    check(writes == 0, "R4", "no writes on clean frame", writes, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule